// File: doc/BRIEF.md
# Beat-Wise Vector Lane Predication Tracker

This block keeps the lane predication state for a vector engine that executes one instruction as four consecutive beats, each beat covering four byte lanes. It holds a 16-bit lane predicate, with one nibble per beat, and an 8-bit step mask made of two 4-bit fields. Field 0 serves beats 0 and 1 and field 1 serves beats 2 and 3. While a beat is in progress the block presents a 4-bit byte-enable for that beat. A mask field of zero means predication is off, and the enable is then all ones. A nonzero field means the enable is the beat's predicate nibble.

A `start` pulse, taken only while the block is idle, begins a sequence of four beat cycles, one per clock. The block drives the beat index itself. The downstream datapath treats `beat_valid` as its one-cycle execute slot. It holds `adv_keep` high to let the predication state advance at the end of that beat, or pulls it low to hold the state unchanged. One cycle after beat 3, `done` pulses.

The predicate and step mask are written through a valid/ready load port. `load_ready` is high only while no sequence is running. A load offered while busy is not accepted, and the source must hold it until `load_ready` returns.

Advancing works on the beat's own mask field. If the field reads 1000, it becomes zero. Any other nonzero field shifts left by one with a zero fill, and a 1 leaving the top bit inverts the current beat's predicate nibble. The new field value is stored only at the second beat of each pair.

Top module: `pred_tracker`

## Requirements
- R1: A synchronous reset clears the predicate and the step mask to zero, leaves the block idle (`beat_valid` low, `load_ready` high) and holds `done` low.
- R2: When `load_valid` and `load_ready` are both high at a clock edge, `load_pred` and `load_mask` replace the predicate and mask. `load_ready` is low during every beat cycle, and a load offered then changes neither register.
- R3: `start` while idle produces exactly four consecutive cycles with `beat_valid` high and `beat_idx` 0, 1, 2, 3. A single-cycle `done` follows in the next cycle with `beat_valid` low. `start` while busy is ignored.
- R4: Beats 0 and 1 use mask bits [3:0] and beats 2 and 3 use mask bits [7:4]. The predicate nibble for beat b is bits [4b+3:4b].
- R5: During a beat whose mask field is zero, `beat_en` is 4'b1111. Otherwise `beat_en` equals that beat's predicate nibble.
- R6: When a beat advances with its field equal to 4'b1000, the field's new value is zero and the predicate is not inverted.
- R7: When a beat advances with any other nonzero field, the field's new value is the field shifted left by one with a zero fill. If the bit shifted out was 1, the current beat's predicate nibble is inverted. A zero field stays zero.
- R8: The new field value is stored only on beats 1 and 3. On beats 0 and 2 the mask register keeps its value, though the predicate inversion still takes effect.
- R9: A beat with `adv_keep` low at its end leaves the predicate and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Load offer for predicate and mask |
| load_ready | output | 1 | High while idle; the load is taken when valid and ready are both high |
| load_pred | input | 16 | Predicate value to load |
| load_mask | input | 8 | Step mask value to load (two 4-bit fields) |
| start | input | 1 | Begins a four-beat sequence when idle |
| adv_keep | input | 1 | Held high during a beat to let the state advance at its end |
| beat_valid | output | 1 | A beat is in progress this cycle |
| beat_idx | output | 2 | Index of the current beat |
| beat_en | output | 4 | Byte-lane enables for the current beat |
| done | output | 1 | One-cycle pulse after the last beat |
| pred_o | output | 16 | Current predicate register |
| mask_o | output | 8 | Current step mask register |

## Verification
On every cycle the assertions check the beat ordering and the `done` that follows beat 3, the enable value against the current mask field and predicate nibble, and that the registers stay put after a held-off beat. They also check that the mask is never written after beats 0 and 2. The exact shifted field values, the inversion when a 1 leaves the top bit, the 1000-to-zero collapse and the rejection of loads and starts while busy depend on whole sequences. Only the bench's scenarios show these, with directed mask patterns such as 8'h88 and 8'hC9 mixed with seeded random predicates, masks and hold patterns, compared against a model of the rules.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pred_beat_seq.sv
module pred_beat_seq
  import pred_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic              done
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_state_e state_q;
  logic [BEAT_W-1:0] beat_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_RUN;
            beat_q  <= '0;
          end
        end
        SEQ_RUN: begin
          if (beat_q == LAST_BEAT) begin
            state_q <= SEQ_IDLE;
            beat_q  <= '0;
            done_q  <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SEQ_RUN);
  assign beat = beat_q;
  assign done = done_q;
endmodule

// File: rtl/pred_enable_lookup.sv
module pred_enable_lookup #(
  parameter int BEATS           = 4,
  parameter int LANES           = 4,
  parameter int FIELD_W         = 4,
  parameter int BEATS_PER_FIELD = 2,
  parameter int BEAT_W          = 2,
  parameter int FIELD_IDX_W     = 1
) (
  input  logic [BEATS*LANES-1:0]                     pred,
  input  logic [(BEATS/BEATS_PER_FIELD)*FIELD_W-1:0] mask,
  input  logic [BEAT_W-1:0]                          beat,
  output logic [FIELD_IDX_W-1:0]                     field_idx,
  output logic [FIELD_W-1:0]                         field_cur,
  output logic [LANES-1:0]                           nib_cur,
  output logic [LANES-1:0]                           beat_en
);
  localparam int FIELDS  = BEATS / BEATS_PER_FIELD;
  localparam int PAIR_SH = $clog2(BEATS_PER_FIELD);

  logic [FIELD_W-1:0] fields [FIELDS];
  logic [LANES-1:0]   nibs   [BEATS];

  for (genvar gf = 0; gf < FIELDS; gf++) begin : g_field
    assign fields[gf] = mask[gf*FIELD_W +: FIELD_W];
  end

  for (genvar gb = 0; gb < BEATS; gb++) begin : g_nib
    assign nibs[gb] = pred[gb*LANES +: LANES];
  end

  assign field_idx = beat[BEAT_W-1:PAIR_SH];
  assign field_cur = fields[field_idx];
  assign nib_cur   = nibs[beat];

  always_comb begin
    beat_en = '1;
    if (field_cur != '0) beat_en = beat_en & nib_cur;
  end
endmodule

// File: rtl/pred_mask_advance.sv
module pred_mask_advance #(
  parameter int FIELD_W = 4,
  parameter int LANES   = 4
) (
  input  logic [FIELD_W-1:0] field_in,
  input  logic [LANES-1:0]   nib_in,
  output logic [FIELD_W-1:0] field_out,
  output logic [LANES-1:0]   nib_out
);
  localparam logic [FIELD_W-1:0] FINAL_STEP = {1'b1, {(FIELD_W-1){1'b0}}};

  always_comb begin
    field_out = field_in;
    nib_out   = nib_in;
    if (field_in == FINAL_STEP) begin
      field_out = '0;
    end else if (field_in != '0) begin
      field_out = {field_in[FIELD_W-2:0], 1'b0};
      if (field_in[FIELD_W-1]) nib_out = ~nib_in;
    end
  end
endmodule

// File: rtl/pred_tracker.sv
module pred_tracker #(
  parameter int BEATS           = 4,
  parameter int LANES           = 4,
  parameter int FIELD_W         = 4,
  parameter int BEATS_PER_FIELD = 2,
  localparam int FIELDS         = BEATS / BEATS_PER_FIELD,
  localparam int PRED_W         = BEATS * LANES,
  localparam int MASK_W         = FIELDS * FIELD_W,
  localparam int BEAT_W         = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [PRED_W-1:0] load_pred,
  input  logic [MASK_W-1:0] load_mask,
  input  logic              start,
  input  logic              adv_keep,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [LANES-1:0]  beat_en,
  output logic              done,
  output logic [PRED_W-1:0] pred_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int PAIR_SH     = $clog2(BEATS_PER_FIELD);
  localparam int FIELD_IDX_W = BEAT_W - PAIR_SH;
  localparam logic [PAIR_SH-1:0] STORE_SLOT = PAIR_SH'(BEATS_PER_FIELD - 1);

  logic [PRED_W-1:0] pred_q;
  logic [MASK_W-1:0] mask_q;

  logic                   busy;
  logic [BEAT_W-1:0]      beat;
  logic [FIELD_IDX_W-1:0] field_idx;
  logic [FIELD_W-1:0]     field_cur, field_next;
  logic [LANES-1:0]       nib_cur, nib_next;
  logic                   commit, store_field, take_load;

  pred_beat_seq #(
    .BEATS (BEATS),
    .BEAT_W(BEAT_W)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .beat (beat),
    .done (done)
  );

  pred_enable_lookup #(
    .BEATS          (BEATS),
    .LANES          (LANES),
    .FIELD_W        (FIELD_W),
    .BEATS_PER_FIELD(BEATS_PER_FIELD),
    .BEAT_W         (BEAT_W),
    .FIELD_IDX_W    (FIELD_IDX_W)
  ) u_lookup (
    .pred     (pred_q),
    .mask     (mask_q),
    .beat     (beat),
    .field_idx(field_idx),
    .field_cur(field_cur),
    .nib_cur  (nib_cur),
    .beat_en  (beat_en)
  );

  pred_mask_advance #(
    .FIELD_W(FIELD_W),
    .LANES  (LANES)
  ) u_adv (
    .field_in (field_cur),
    .nib_in   (nib_cur),
    .field_out(field_next),
    .nib_out  (nib_next)
  );

  assign take_load   = load_valid && !busy;
  assign commit      = busy && adv_keep;
  assign store_field = commit && (beat[PAIR_SH-1:0] == STORE_SLOT);

  for (genvar gb = 0; gb < BEATS; gb++) begin : g_pred_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        pred_q[gb*LANES +: LANES] <= '0;
      end else if (take_load) begin
        pred_q[gb*LANES +: LANES] <= load_pred[gb*LANES +: LANES];
      end else if (commit && (beat == BEAT_W'(gb))) begin
        pred_q[gb*LANES +: LANES] <= nib_next;
      end
    end
  end

  for (genvar gf = 0; gf < FIELDS; gf++) begin : g_mask_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[gf*FIELD_W +: FIELD_W] <= '0;
      end else if (take_load) begin
        mask_q[gf*FIELD_W +: FIELD_W] <= load_mask[gf*FIELD_W +: FIELD_W];
      end else if (store_field && (field_idx == FIELD_IDX_W'(gf))) begin
        mask_q[gf*FIELD_W +: FIELD_W] <= field_next;
      end
    end
  end

  assign load_ready = !busy;
  assign beat_valid = busy;
  assign beat_idx   = beat;
  assign pred_o     = pred_q;
  assign mask_o     = mask_q;
endmodule

// File: rtl/pred_tracker_chk.sv
module pred_tracker_chk #(
  parameter int BEATS           = 4,
  parameter int LANES           = 4,
  parameter int FIELD_W         = 4,
  parameter int BEATS_PER_FIELD = 2,
  localparam int FIELDS         = BEATS / BEATS_PER_FIELD,
  localparam int PRED_W         = BEATS * LANES,
  localparam int MASK_W         = FIELDS * FIELD_W,
  localparam int BEAT_W         = $clog2(BEATS)
) (
  input logic              clk,
  input logic              rst,
  input logic              load_valid,
  input logic              load_ready,
  input logic [PRED_W-1:0] load_pred,
  input logic [MASK_W-1:0] load_mask,
  input logic              start,
  input logic              adv_keep,
  input logic              beat_valid,
  input logic [BEAT_W-1:0] beat_idx,
  input logic [LANES-1:0]  beat_en,
  input logic              done,
  input logic [PRED_W-1:0] pred_o,
  input logic [MASK_W-1:0] mask_o
);
  localparam int PAIR_SH = $clog2(BEATS_PER_FIELD);
  localparam logic [BEAT_W-1:0]  LAST_BEAT  = BEAT_W'(BEATS - 1);
  localparam logic [PAIR_SH-1:0] STORE_SLOT = PAIR_SH'(BEATS_PER_FIELD - 1);

  logic [FIELD_W-1:0] fld_seen;
  logic [LANES-1:0]   nib_seen;

  assign fld_seen = FIELD_W'(mask_o >> (FIELD_W * (int'(beat_idx) >> PAIR_SH)));
  assign nib_seen = LANES'(pred_o >> (LANES * int'(beat_idx)));

  assert_off_enables_all_R5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && fld_seen == '0) |-> (beat_en == '1));

  assert_on_enables_nibble_R5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && fld_seen != '0) |-> (beat_en == nib_seen));

  assert_beat_order_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_idx != LAST_BEAT) |=>
      (beat_valid && beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_idx == LAST_BEAT) |=> (done && !beat_valid));

  assert_hold_when_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !adv_keep) |=> ($stable(pred_o) && $stable(mask_o)));

  assert_mask_kept_first_of_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_idx[PAIR_SH-1:0] != STORE_SLOT) |=> $stable(mask_o));
endmodule

bind pred_tracker pred_tracker_chk #(
  .BEATS          (BEATS),
  .LANES          (LANES),
  .FIELD_W        (FIELD_W),
  .BEATS_PER_FIELD(BEATS_PER_FIELD)
) u_chk (.*);

// File: tb/pred_tracker_bench.sv
module pred_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_pred = '0;
  logic [7:0]  load_mask = '0;
  logic        start = 1'b0;
  logic        adv_keep = 1'b0;
  logic        beat_valid;
  logic [1:0]  beat_idx;
  logic [3:0]  beat_en;
  logic        done;
  logic [15:0] pred_o;
  logic [7:0]  mask_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] mp;
  logic [7:0]  mm;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_tracker u_pred_tracker (
    .clk(clk), .rst(rst),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_pred(load_pred), .load_mask(load_mask),
    .start(start), .adv_keep(adv_keep),
    .beat_valid(beat_valid), .beat_idx(beat_idx), .beat_en(beat_en),
    .done(done), .pred_o(pred_o), .mask_o(mask_o)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] model_en(input logic [15:0] p, input logic [7:0] m, input int b);
    logic [3:0] f;
    f = m[(b/2)*4 +: 4];
    return (f != 4'h0) ? p[b*4 +: 4] : 4'hF;
  endfunction

  function automatic logic [23:0] model_step(input logic [15:0] p, input logic [7:0] m, input int b);
    logic [3:0] f, nf;
    f  = m[(b/2)*4 +: 4];
    nf = f;
    if (f == 4'b1000) nf = 4'h0;
    else if (f != 4'h0) begin
      nf = {f[2:0], 1'b0};
      if (f[3]) p[b*4 +: 4] = ~p[b*4 +: 4];
    end
    if (b % 2 == 1) m[(b/2)*4 +: 4] = nf;
    return {p, m};
  endfunction

  task automatic do_load(input logic [15:0] p, input logic [7:0] m);
    check(load_ready == 1'b1, "R2 ready while idle", 32'(load_ready), 32'd1);
    load_valid = 1'b1; load_pred = p; load_mask = m;
    @(posedge clk); #1;
    load_valid = 1'b0;
    mp = p; mm = m;
    check(pred_o == p, "R2 predicate loaded", 32'(pred_o), 32'(p));
    check(mask_o == m, "R2 mask loaded", 32'(mask_o), 32'(m));
  endtask

  task automatic run_seq(input logic [3:0] keep, input bit poke);
    logic [23:0] nx;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int b = 0; b < 4; b++) begin
      check(beat_valid == 1'b1, "R3 beat_valid in sequence", 32'(beat_valid), 32'd1);
      check(beat_idx == 2'(b), "R3 beat index order", 32'(beat_idx), 32'(b));
      check(load_ready == 1'b0, "R2 ready low while busy", 32'(load_ready), 32'd0);
      check(beat_en == model_en(mp, mm, b), "R4 R5 beat enables", 32'(beat_en), 32'(model_en(mp, mm, b)));
      adv_keep = keep[b];
      if (poke) begin
        load_valid = 1'b1; load_pred = 16'(~mp); load_mask = 8'(~mm); start = 1'b1;
      end
      @(posedge clk); #1;
      load_valid = 1'b0; start = 1'b0; adv_keep = 1'b0;
      if (keep[b]) begin
        nx = model_step(mp, mm, b);
        mp = nx[23:8]; mm = nx[7:0];
      end
      check(pred_o == mp, "R7 R9 R2 predicate after beat", 32'(pred_o), 32'(mp));
      check(mask_o == mm, "R6 R8 R9 R2 mask after beat", 32'(mask_o), 32'(mm));
    end
    check(done == 1'b1, "R3 done after last beat", 32'(done), 32'd1);
    check(beat_valid == 1'b0, "R3 idle after last beat", 32'(beat_valid), 32'd0);
    @(posedge clk); #1;
    check(done == 1'b0, "R3 done is one cycle", 32'(done), 32'd0);
    check(beat_valid == 1'b0, "R3 busy start ignored", 32'(beat_valid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    // R1: reset state
    check(pred_o == 16'h0, "R1 predicate reset", 32'(pred_o), 32'd0);
    check(mask_o == 8'h0, "R1 mask reset", 32'(mask_o), 32'd0);
    check(beat_valid == 1'b0, "R1 idle after reset", 32'(beat_valid), 32'd0);
    check(load_ready == 1'b1, "R1 ready after reset", 32'(load_ready), 32'd1);
    check(done == 1'b0, "R1 done low after reset", 32'(done), 32'd0);

    // R5: predication off, enables all ones
    do_load(16'hA5C3, 8'h00);
    run_seq(4'hF, 1'b0);
    // R6: 1000 fields collapse to zero without inversion
    do_load(16'h1234, 8'h88);
    run_seq(4'hF, 1'b0);
    // R7 R8: shifts with inversion, store on odd beats only
    do_load(16'hF0F0, 8'hC9);
    run_seq(4'hF, 1'b0);
    run_seq(4'hF, 1'b0);
    // R9: held-off beats
    do_load(16'h5A5A, 8'hFF);
    run_seq(4'b0101, 1'b0);
    run_seq(4'b1010, 1'b0);
    // R2 R3: loads and starts offered while busy are ignored
    do_load(16'h0FF0, 8'h4E);
    run_seq(4'hF, 1'b1);

    for (int i = 0; i < 60; i++) begin
      if (($urandom % 3) != 0) do_load(16'($urandom), 8'($urandom));
      run_seq(4'($urandom), 1'($urandom));
    end

    // R1: reset mid-run clears state
    do_load(16'hBEEF, 8'h37);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check(pred_o == 16'h0 && mask_o == 8'h0, "R1 reset during run",
          32'({pred_o, mask_o}), 32'd0);
    check(beat_valid == 1'b0, "R1 idle after mid-run reset", 32'(beat_valid), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule